// File: doc/BRIEF.md
# Paired-Page TLB Lookup Unit

This block is a fully associative translation buffer for a 32-bit processor. Each entry describes two neighbouring virtual pages at once (an even page and an odd page), with a page size chosen per entry through a mask, its own physical frame base for each page, and separate valid and dirty bits for each page. An entry is either tied to one 8-bit address-space identifier or marked global so that any identifier hits it.

On a request strobe the unit compares the virtual address against every entry in the same cycle. One clock later it presents a result code, the translated physical address, read and write permission, and the index of the entry that answered. Entries are loaded through a single indexed write port. The write lands on the next clock edge.

The control is a two-state machine. `ST_IDLE` means no result is on show. `ST_SHOW` means the response registers hold a fresh result. The transitions are:
- `GO_SHOW`: a request in `ST_IDLE` moves to `ST_SHOW`.
- `RE_SHOW`: a request in `ST_SHOW` stays there with the new result.
- `GO_IDLE`: no request returns to `ST_IDLE`.

Top module: `tlbpp_unit`

## Requirements
- R1: After reset `rsp_valid` is 0, `rsp_code` is 1 (no-match) and `rsp_pa` is 0. Every entry is cleared to all-zero fields, which means not valid, not global and identifier 0.
- R2: `rsp_valid` is 1 exactly in the cycle after a cycle with `req` high. Back-to-back requests give back-to-back responses in request order.
- R3: An entry can take part only when its global bit is 1 or its identifier equals `cur_asid`.
- R4: The effective mask is `mask | 0x1FFF`. The address and the entry's `vpn` must be equal in every bit where the effective mask is 0.
- R5: The odd page of the pair is selected when the address bit at the top of the effective mask is 1. That is bit 12 for the smallest (4 KB) pages.
- R6: On a hit, `rsp_pa` equals the selected page's frame base ORed with the address bits covered by the effective mask shifted right by one.
- R7: If the selected page's valid bit is 0, the code is 2 (invalid).
- R8: A write to a valid page whose dirty bit is 0 gives code 3 (dirty violation). A read of the same page gives code 0 with `rsp_wr_ok` 0.
- R9: On code 0, `rsp_rd_ok` is 1 and `rsp_wr_ok` equals the selected dirty bit. On any other code, `rsp_pa`, `rsp_rd_ok` and `rsp_wr_ok` are 0.
- R10: If no entry passes R3 and R4, the code is 1 (no-match) and `rsp_idx` is 0.
- R11: When several entries pass, the lowest index answers, even if its selected page is invalid. `rsp_idx` reports that index.
- R12: A lookup in the same cycle as an entry write sees the old contents. A lookup one cycle later sees the new ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Lookup strobe |
| req_va | input | 32 | Virtual address to translate |
| req_wr | input | 1 | 1 for a store access, 0 for a load |
| cur_asid | input | 8 | Current address-space identifier |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | IDX_W | Entry to write |
| wr_vpn | input | 32 | Virtual page-pair number (address bits) |
| wr_mask | input | 32 | Page mask (address bits) |
| wr_global | input | 1 | Global bit |
| wr_asid | input | 8 | Entry identifier |
| wr_pfn0 | input | 32 | Even page frame base |
| wr_pfn1 | input | 32 | Odd page frame base |
| wr_v0 | input | 1 | Even page valid |
| wr_v1 | input | 1 | Odd page valid |
| wr_d0 | input | 1 | Even page dirty (writable) |
| wr_d1 | input | 1 | Odd page dirty (writable) |
| rsp_valid | output | 1 | Result present this cycle |
| rsp_code | output | 2 | 0 hit, 1 no-match, 2 invalid, 3 dirty violation |
| rsp_pa | output | 32 | Physical address |
| rsp_rd_ok | output | 1 | Read permitted |
| rsp_wr_ok | output | 1 | Write permitted |
| rsp_idx | output | IDX_W | Answering entry |

## Verification
The hardest situations to reach from the ports are two entries that both claim the same address, and a lookup that coincides with a write to the entry it would hit. The stimulus loads two global entries with the same page pair at indices 2 and 3 and checks that index 2 answers. It then reloads index 2 with its page invalid and checks that index 2 still answers, now with code 2. Separately, it raises the write strobe and the lookup strobe in the same cycle and expects no-match, then repeats the lookup alone and expects a hit.

// File: rtl/tlbpp_pkg.sv
package tlbpp_pkg;
    localparam int ADDR_W   = 32;
    localparam int ASID_W   = 8;
    localparam int PAIR_LOW = 13;  // bits always inside the effective mask

    typedef enum logic [1:0] {
        RC_HIT   = 2'd0,
        RC_MISS  = 2'd1,
        RC_INVAL = 2'd2,
        RC_CLEAN = 2'd3
    } res_code_t;

    typedef struct packed {
        logic [ADDR_W-1:0] vpn;
        logic [ADDR_W-1:0] mask;
        logic              glob;
        logic [ASID_W-1:0] asid;
        logic [ADDR_W-1:0] pfn0;
        logic [ADDR_W-1:0] pfn1;
        logic              v0;
        logic              v1;
        logic              d0;
        logic              d1;
    } tlb_ent_t;
endpackage

// File: rtl/tlbpp_store.sv
module tlbpp_store
    import tlbpp_pkg::*;
#(
    parameter int N_ENT = 16,
    localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  tlb_ent_t         wr_ent,
    output tlb_ent_t         ents [N_ENT]
);
    for (genvar i = 0; i < N_ENT; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ents[i] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(i))) begin
                ents[i] <= wr_ent;
            end
        end
    end
endmodule

// File: rtl/tlbpp_match.sv
module tlbpp_match
    import tlbpp_pkg::*;
(
    input  tlb_ent_t          ent,
    input  logic [ADDR_W-1:0] va,
    input  logic [ASID_W-1:0] asid,
    output logic              hit,
    output logic              pg_v,
    output logic              pg_d,
    output logic [ADDR_W-1:0] pa
);
    localparam logic [ADDR_W-1:0] LOW_FILL = ADDR_W'((64'd1 << PAIR_LOW) - 64'd1);

    logic [ADDR_W-1:0] emask;
    logic [ADDR_W-1:0] half;
    logic              odd;
    logic              id_ok;

    always_comb begin
        emask = ent.mask | LOW_FILL;
        half  = emask >> 1;
        id_ok = ent.glob || (ent.asid == asid);
        hit   = id_ok && ((va & ~emask) == (ent.vpn & ~emask));
        odd   = |(va & emask & ~half);
        pg_v  = odd ? ent.v1 : ent.v0;
        pg_d  = odd ? ent.d1 : ent.d0;
        pa    = (odd ? ent.pfn1 : ent.pfn0) | (va & half);
    end
endmodule

// File: rtl/tlbpp_select.sv
module tlbpp_select #(
    parameter int N_ENT = 16,
    localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic [N_ENT-1:0] hits,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (hits[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/tlbpp_unit.sv
module tlbpp_unit
    import tlbpp_pkg::*;
#(
    parameter int N_ENT = 16,
    localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic [31:0]      req_va,
    input  logic             req_wr,
    input  logic [7:0]       cur_asid,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [31:0]      wr_vpn,
    input  logic [31:0]      wr_mask,
    input  logic             wr_global,
    input  logic [7:0]       wr_asid,
    input  logic [31:0]      wr_pfn0,
    input  logic [31:0]      wr_pfn1,
    input  logic             wr_v0,
    input  logic             wr_v1,
    input  logic             wr_d0,
    input  logic             wr_d1,
    output logic             rsp_valid,
    output logic [1:0]       rsp_code,
    output logic [31:0]      rsp_pa,
    output logic             rsp_rd_ok,
    output logic             rsp_wr_ok,
    output logic [IDX_W-1:0] rsp_idx
);
    typedef enum logic {ST_IDLE = 1'b0, ST_SHOW = 1'b1} st_t;

    st_t state_q, state_d;

    tlb_ent_t          wr_ent;
    tlb_ent_t          ents [N_ENT];
    logic [N_ENT-1:0]  hits;
    logic [N_ENT-1:0]  pg_v;
    logic [N_ENT-1:0]  pg_d;
    logic [ADDR_W-1:0] pa_of [N_ENT];
    logic              found;
    logic [IDX_W-1:0]  win;

    res_code_t         code_c;
    logic [ADDR_W-1:0] pa_c;
    logic              rd_c, wr_c;

    res_code_t         code_q;
    logic [ADDR_W-1:0] pa_q;
    logic              rd_q, wr_q;
    logic [IDX_W-1:0]  idx_q;

    always_comb begin
        wr_ent.vpn  = wr_vpn;
        wr_ent.mask = wr_mask;
        wr_ent.glob = wr_global;
        wr_ent.asid = wr_asid;
        wr_ent.pfn0 = wr_pfn0;
        wr_ent.pfn1 = wr_pfn1;
        wr_ent.v0   = wr_v0;
        wr_ent.v1   = wr_v1;
        wr_ent.d0   = wr_d0;
        wr_ent.d1   = wr_d1;
    end

    tlbpp_store #(.N_ENT(N_ENT)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_ent (wr_ent),
        .ents   (ents)
    );

    for (genvar i = 0; i < N_ENT; i++) begin : g_cmp
        tlbpp_match u_match (
            .ent  (ents[i]),
            .va   (req_va),
            .asid (cur_asid),
            .hit  (hits[i]),
            .pg_v (pg_v[i]),
            .pg_d (pg_d[i]),
            .pa   (pa_of[i])
        );
    end

    tlbpp_select #(.N_ENT(N_ENT)) u_sel (
        .hits  (hits),
        .found (found),
        .idx   (win)
    );

    // Result classification for the winning entry.
    always_comb begin
        code_c = RC_MISS;
        pa_c   = '0;
        rd_c   = 1'b0;
        wr_c   = 1'b0;
        if (found) begin
            if (!pg_v[win]) begin
                code_c = RC_INVAL;
            end else if (req_wr && !pg_d[win]) begin
                code_c = RC_CLEAN;
            end else begin
                code_c = RC_HIT;
                pa_c   = pa_of[win];
                rd_c   = 1'b1;
                wr_c   = pg_d[win];
            end
        end
    end

    // State register.
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = req ? ST_SHOW : ST_IDLE;
            ST_SHOW: state_d = req ? ST_SHOW : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= RC_MISS;
            pa_q   <= '0;
            rd_q   <= 1'b0;
            wr_q   <= 1'b0;
            idx_q  <= '0;
        end else if (req) begin
            code_q <= code_c;
            pa_q   <= pa_c;
            rd_q   <= rd_c;
            wr_q   <= wr_c;
            idx_q  <= found ? win : '0;
        end
    end

    assign rsp_valid = (state_q == ST_SHOW);
    assign rsp_code  = code_q;
    assign rsp_pa    = pa_q;
    assign rsp_rd_ok = rd_q;
    assign rsp_wr_ok = wr_q;
    assign rsp_idx   = idx_q;
endmodule

// File: rtl/tlbpp_check.sv
module tlbpp_check (
    input logic       clk,
    input logic       rst_n,
    input logic       req,
    input logic       req_wr,
    input logic       rsp_valid,
    input logic [1:0] rsp_code,
    input logic [31:0] rsp_pa,
    input logic       rsp_rd_ok,
    input logic       rsp_wr_ok
);
    assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> rsp_valid);

    assert_no_spurious_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !rsp_valid);

    assert_fail_no_perm_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_code != 2'd0) |-> (!rsp_rd_ok && !rsp_wr_ok && rsp_pa == 32'd0));

    assert_hit_reads_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code == 2'd0) |-> rsp_rd_ok);

    assert_read_never_dirty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !req_wr) |=> (rsp_code != 2'd3));
endmodule

bind tlbpp_unit tlbpp_check u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .req_wr    (req_wr),
    .rsp_valid (rsp_valid),
    .rsp_code  (rsp_code),
    .rsp_pa    (rsp_pa),
    .rsp_rd_ok (rsp_rd_ok),
    .rsp_wr_ok (rsp_wr_ok)
);

// File: tb/tlbpp_unit_test.sv
module tlbpp_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int N_ENT = 16;
    localparam int IDX_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req = 1'b0;
    logic [31:0]      req_va = '0;
    logic             req_wr = 1'b0;
    logic [7:0]       cur_asid = '0;
    logic             wr_en = 1'b0;
    logic [IDX_W-1:0] wr_idx = '0;
    logic [31:0]      wr_vpn = '0, wr_mask = '0, wr_pfn0 = '0, wr_pfn1 = '0;
    logic             wr_global = 1'b0;
    logic [7:0]       wr_asid = '0;
    logic             wr_v0 = 0, wr_v1 = 0, wr_d0 = 0, wr_d1 = 0;
    logic             rsp_valid;
    logic [1:0]       rsp_code;
    logic [31:0]      rsp_pa;
    logic             rsp_rd_ok, rsp_wr_ok;
    logic [IDX_W-1:0] rsp_idx;

    int n_checks = 0;
    int n_bad = 0;
    bit finished = 0;

    typedef struct {
        logic [1:0]  code;
        logic [31:0] pa;
        logic        rd;
        logic        wr;
        logic [3:0]  idx;
        string       tag;
    } exp_t;

    exp_t expq[$];

    tlbpp_unit #(.N_ENT(N_ENT)) uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Monitor: compare each response against the queued expectation.
    always @(negedge clk) begin
        if (rst_n && rsp_valid && !finished) begin
            if (expq.size() == 0) begin
                check(0, "R2", "unexpected response", 32'(rsp_code), 32'hFFFF_FFFF);
            end else begin
                exp_t e;
                e = expq.pop_front();
                check(rsp_code == e.code, e.tag, "code", 32'(rsp_code), 32'(e.code));
                check(rsp_pa == e.pa, e.tag, "pa", rsp_pa, e.pa);
                check(rsp_rd_ok == e.rd && rsp_wr_ok == e.wr, e.tag, "rd/wr",
                      {30'd0, rsp_rd_ok, rsp_wr_ok}, {30'd0, e.rd, e.wr});
                check(rsp_idx == e.idx, e.tag, "idx", 32'(rsp_idx), 32'(e.idx));
            end
        end
    end

    task automatic put_entry(input int idx, input logic [31:0] vpn, input logic [31:0] msk,
                             input logic g, input logic [7:0] id,
                             input logic [31:0] p0, input logic [31:0] p1,
                             input logic v0, input logic v1, input logic d0, input logic d1);
        wr_en = 1'b1; wr_idx = IDX_W'(idx); wr_vpn = vpn; wr_mask = msk;
        wr_global = g; wr_asid = id; wr_pfn0 = p0; wr_pfn1 = p1;
        wr_v0 = v0; wr_v1 = v1; wr_d0 = d0; wr_d1 = d1;
    endtask

    task automatic start_look(input logic [31:0] va, input logic w, input logic [7:0] id,
                              input logic [1:0] code, input logic [31:0] pa,
                              input logic rd, input logic wok, input int idx, input string tag);
        exp_t e;
        req = 1'b1; req_va = va; req_wr = w; cur_asid = id;
        e.code = code; e.pa = pa; e.rd = rd; e.wr = wok; e.idx = 4'(idx); e.tag = tag;
        expq.push_back(e);
    endtask

    task automatic load(input int idx, input logic [31:0] vpn, input logic [31:0] msk,
                        input logic g, input logic [7:0] id,
                        input logic [31:0] p0, input logic [31:0] p1,
                        input logic v0, input logic v1, input logic d0, input logic d1);
        @(posedge clk); #1;
        put_entry(idx, vpn, msk, g, id, p0, p1, v0, v1, d0, d1);
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic look(input logic [31:0] va, input logic w, input logic [7:0] id,
                        input logic [1:0] code, input logic [31:0] pa,
                        input logic rd, input logic wok, input int idx, input string tag);
        @(posedge clk); #1;
        start_look(va, w, id, code, pa, rd, wok, idx, tag);
        @(posedge clk); #1;
        req = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        check(0, "R2", "watchdog expired", 32'd0, 32'd1);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state of the outputs
        check(rsp_valid == 1'b0, "R1", "valid after reset", 32'(rsp_valid), 32'd0);
        check(rsp_code == 2'd1, "R1", "code after reset", 32'(rsp_code), 32'd1);
        check(rsp_pa == 32'd0, "R1", "pa after reset", rsp_pa, 32'd0);
        // R1/R10: cleared entries give no-match for a foreign identifier
        look(32'h0000_1234, 0, 8'h55, 2'd1, 32'd0, 0, 0, 0, "R1");

        // Entry 0: 4 KB pages, identifier 0x11, even dirty, odd clean
        load(0, 32'h0040_0000, 32'h0, 0, 8'h11, 32'h1000_0000, 32'h2000_0000, 1, 1, 1, 0);
        look(32'h0040_0123, 0, 8'h11, 2'd0, 32'h1000_0123, 1, 1, 0, "R6");
        look(32'h0040_1ABC, 0, 8'h11, 2'd0, 32'h2000_0ABC, 1, 0, 0, "R5");
        look(32'h0040_1ABC, 1, 8'h11, 2'd3, 32'd0, 0, 0, 0, "R8");
        look(32'h0040_0010, 1, 8'h11, 2'd0, 32'h1000_0010, 1, 1, 0, "R9");
        look(32'h0040_0010, 0, 8'h22, 2'd1, 32'd0, 0, 0, 0, "R3");
        look(32'h0060_0010, 0, 8'h11, 2'd1, 32'd0, 0, 0, 0, "R10");

        // Entry 1: global, 64 KB pages, odd page invalid
        load(1, 32'h0100_0000, 32'h0001_E000, 1, 8'h99, 32'h3000_0000, 32'h3001_0000, 1, 0, 1, 0);
        look(32'h0100_ABCD, 1, 8'h22, 2'd0, 32'h3000_ABCD, 1, 1, 1, "R3");
        look(32'h0100_F000, 0, 8'h77, 2'd0, 32'h3000_F000, 1, 1, 1, "R4");
        look(32'h0101_2345, 0, 8'h22, 2'd2, 32'd0, 0, 0, 1, "R7");
        look(32'h0102_0000, 0, 8'h22, 2'd1, 32'd0, 0, 0, 0, "R4");

        // Entries 2 and 3 overlap: lowest index answers
        load(3, 32'h0800_0000, 32'h0, 1, 8'h00, 32'h5000_0000, 32'h5000_1000, 1, 1, 0, 0);
        load(2, 32'h0800_0000, 32'h0, 1, 8'h00, 32'h4000_0000, 32'h4000_1000, 1, 1, 0, 0);
        look(32'h0800_0004, 0, 8'h33, 2'd0, 32'h4000_0004, 1, 0, 2, "R11");
        load(2, 32'h0800_0000, 32'h0, 1, 8'h00, 32'h4000_0000, 32'h4000_1000, 0, 1, 0, 0);
        look(32'h0800_0004, 0, 8'h33, 2'd2, 32'd0, 0, 0, 2, "R11");

        // Highest index
        load(15, 32'hC000_0000, 32'h0, 0, 8'h11, 32'h7000_0000, 32'h7000_1000, 1, 1, 1, 1);
        look(32'hC000_1FFF, 1, 8'h11, 2'd0, 32'h7000_1FFF, 1, 1, 15, "R11");

        // R12: write and lookup in the same cycle
        @(posedge clk); #1;
        put_entry(4, 32'h0900_0000, 32'h0, 0, 8'h11, 32'h6000_0000, 32'h6000_1000, 1, 1, 1, 1);
        start_look(32'h0900_0040, 0, 8'h11, 2'd1, 32'd0, 0, 0, 0, "R12");
        @(posedge clk); #1;
        wr_en = 1'b0;
        start_look(32'h0900_0040, 0, 8'h11, 2'd0, 32'h6000_0040, 1, 1, 4, "R12");
        // R2: third back-to-back request
        @(posedge clk); #1;
        start_look(32'h0040_0020, 0, 8'h11, 2'd0, 32'h1000_0020, 1, 1, 0, "R2");
        @(posedge clk); #1;
        req = 1'b0;

        repeat (4) @(posedge clk);
        @(negedge clk);
        check(expq.size() == 0, "R2", "missing responses", 32'(expq.size()), 32'd0);
        check(rsp_valid == 1'b0, "R2", "valid when idle", 32'(rsp_valid), 32'd0);
        finish_run();
    end
endmodule